// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register front end of a single descriptor-driven DMA channel. Software reaches it over a 32-bit register bus with separate write and read ports. Every write to the channel control location carries a 16-bit per-bit enable in its upper half and the new bit values in its lower half. Software can therefore set or clear any run-state or device status bit without a read-modify-write sequence. The resulting 16-bit status word can be read at its own read-only location.

The status word has two halves. The upper half holds the channel run state: run, pause, flush, wake and dead are held in the block, and active is taken from the channel engine. The lower eight bits are device status bits, which both software and attached hardware can change. Three selector registers, for interrupt, branch and wait, each hold an 8-bit mask and an 8-bit match value. Each one drives a condition flag that is true when the masked device status equals its value. The block also holds a command pointer that addresses 16-byte descriptor slots, along with a high address word.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every held status bit, both command pointer words and all selector masks and values are zero.
- R2: A write to offset 0x00 uses bits 31:16 as an enable mask and bits 15:0 as new values. Each held bit (run=15, pause=14, flush=13, wake=12, dead=11, device bits 7:0) takes the new value only where its enable bit is 1, and otherwise keeps its old value.
- R3: Status bit 10 (active) always shows the eng_active input, and bits 9:8 always read as zero. Enable bits 10:8 in a control write change nothing.
- R4: When hw_stb is high, each device status bit whose hw_mask bit is 1 takes the matching hw_val bit. If a control write enables the same bit in the same cycle, the software value is taken instead.
- R5: The interrupt, branch and wait selectors are at offsets 0x10, 0x14 and 0x18. A write stores bits 23:16 as the mask and bits 7:0 as the value. A read returns the mask in bits 23:16, the value in bits 7:0 and zeros elsewhere.
- R6: int_cond, br_cond and wait_cond are each true exactly when (device status AND mask) equals value for their own selector.
- R7: Offset 0x0C holds the command pointer and reads back the written value with bits 3:0 forced to zero, so it always points at a 16-byte slot. Offset 0x08 holds the full 32-bit high address word. Both words also appear on output ports.
- R8: Offset 0x04 returns the status word and ignores writes. Offset 0x00 reads as zero.
- R9: The run, pause, flush, wake and dead outputs show status bits 15, 14, 13, 12 and 11.
- R10: Any other offset reads as zero, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| hw_stb | input | 1 | Hardware device status update strobe |
| hw_mask | input | 8 | Device bits changed by the hardware strobe |
| hw_val | input | 8 | New values for the hardware strobe |
| eng_active | input | 1 | Engine active flag, shown as status bit 10 |
| run | output | 1 | Run state bit |
| pause | output | 1 | Pause state bit |
| flush | output | 1 | Flush state bit |
| wake | output | 1 | Wake state bit |
| dead | output | 1 | Dead state bit |
| int_cond | output | 1 | Interrupt selector match |
| br_cond | output | 1 | Branch selector match |
| wait_cond | output | 1 | Wait selector match |
| cmd_ptr | output | 32 | Command pointer, 16-byte aligned |
| cmd_ptr_hi | output | 32 | Command pointer high word |

## Verification
The checker takes for granted that every input is known at each rising edge. It also assumes the hardware update mask and value carry meaning only while hw_stb is high, so a stable device status is claimed only for cycles with neither a strobe nor a control write. The stimulus drives all inputs on the falling edge with defined values. It mixes directed run, wake and stop sequences with random offsets drawn from both mapped and unmapped locations, and random strobes that often collide with control writes on the same device bits.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              hw_stb,
  input  logic [7:0]        hw_mask,
  input  logic [7:0]        hw_val,
  input  logic              eng_active,
  output logic              run,
  output logic              pause,
  output logic              flush,
  output logic              wake,
  output logic              dead,
  output logic              int_cond,
  output logic              br_cond,
  output logic              wait_cond,
  output logic [31:0]       cmd_ptr,
  output logic [31:0]       cmd_ptr_hi
);
  localparam int NSEL = 3;
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_CPHI = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_CP   = ADDR_W'(12);
  localparam int SEL_BASE = 16;

  logic [4:0]  rs_q;
  logic [7:0]  dev_q, dev_d;
  logic [31:4] cp_q;
  logic [31:0] cph_q;
  logic [NSEL-1:0][7:0] sel_m_q, sel_v_q;
  logic [NSEL-1:0] cond;
  logic [15:0] status_w;

  wire        ctl_wr = wr_en && (wr_addr == OFF_CTRL);
  wire [15:0] wm = wr_data[31:16];
  wire [15:0] wv = wr_data[15:0];

  always_comb begin
    dev_d = dev_q;
    if (hw_stb) dev_d = (dev_d & ~hw_mask) | (hw_val & hw_mask);
    if (ctl_wr) dev_d = (dev_d & ~wm[7:0]) | (wv[7:0] & wm[7:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_q  <= '0;
      dev_q <= '0;
      cp_q  <= '0;
      cph_q <= '0;
    end else begin
      dev_q <= dev_d;
      if (ctl_wr) rs_q <= (rs_q & ~wm[15:11]) | (wv[15:11] & wm[15:11]);
      if (wr_en && wr_addr == OFF_CP)   cp_q  <= wr_data[31:4];
      if (wr_en && wr_addr == OFF_CPHI) cph_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(SEL_BASE + 4 * g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_m_q[g] <= '0;
        sel_v_q[g] <= '0;
      end else if (wr_en && wr_addr == OFF) begin
        sel_m_q[g] <= wr_data[23:16];
        sel_v_q[g] <= wr_data[7:0];
      end
    end
    assign cond[g] = (dev_q & sel_m_q[g]) == sel_v_q[g];
  end

  assign status_w = {rs_q, eng_active, 2'b00, dev_q};

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFF_STAT) rd_data = {16'h0, status_w};
    if (rd_addr == OFF_CPHI) rd_data = cph_q;
    if (rd_addr == OFF_CP)   rd_data = {cp_q, 4'h0};
    for (int i = 0; i < NSEL; i++)
      if (rd_addr == ADDR_W'(SEL_BASE + 4 * i))
        rd_data = {8'h0, sel_m_q[i], 8'h0, sel_v_q[i]};
  end

  assign {run, pause, flush, wake, dead} = rs_q;
  assign int_cond   = cond[0];
  assign br_cond    = cond[1];
  assign wait_cond  = cond[2];
  assign cmd_ptr    = {cp_q, 4'h0};
  assign cmd_ptr_hi = cph_q;
endmodule

module dma_chan_regs_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              hw_stb,
  input logic              eng_active,
  input logic              run,
  input logic              dead,
  input logic [7:0]        dev_q,
  input logic [31:0]       cmd_ptr,
  input logic [31:0]       cmd_ptr_hi
);
  wire ctl = wr_en && wr_addr == ADDR_W'(0);

  AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && !wr_data[31]) |=> run == $past(run)); // R2
  AST_RUN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && wr_data[31]) |=> run == $past(wr_data[15])); // R2
  AST_DEAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && wr_data[27]) |=> dead == $past(wr_data[11])); // R9
  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && wr_data[16]) |=> dev_q[0] == $past(wr_data[0])); // R4
  AST_DEV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stb && !ctl) |=> $stable(dev_q)); // R4
  AST_ACTIVE_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(4)) |-> (rd_data[10] == eng_active && rd_data[9:8] == 2'b00)); // R3
  AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr[3:0] == 4'h0); // R7
  AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_W'(8)) |=> $stable(cmd_ptr_hi)); // R7
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .hw_stb(hw_stb), .eng_active(eng_active),
  .run(run), .dead(dead), .dev_q(dev_q), .cmd_ptr(cmd_ptr), .cmd_ptr_hi(cmd_ptr_hi)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, wr_en = 0, hw_stb = 0, eng_active = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, cmd_ptr, cmd_ptr_hi;
  logic [7:0] hw_mask = '0, hw_val = '0;
  logic run, pause, flush, wake, dead, int_cond, br_cond, wait_cond;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW)) dut_i (.*);

  logic [15:0] m_st;
  logic [31:0] m_cp, m_cph;
  logic [7:0]  m_sm [3];
  logic [7:0]  m_sv [3];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(int a);
    if (a == 4) return {16'h0, m_st[15:11], eng_active, 2'b00, m_st[7:0]};
    if (a == 8) return m_cph;
    if (a == 12) return m_cp;
    for (int i = 0; i < 3; i++)
      if (a == 16 + 4 * i) return {8'h0, m_sm[i], 8'h0, m_sv[i]};
    return 32'h0;
  endfunction

  function automatic string rd_tag(int a);
    if (a == 4) return "R8/R3 status read";
    if (a == 8 || a == 12) return "R7 pointer read";
    if (a >= 16 && a <= 24) return "R5 selector read";
    if (a == 0) return "R8 control reads zero";
    return "R10 unmapped read";
  endfunction

  task automatic compare_all();
    chk("R9 run-state outputs", {27'h0, run, pause, flush, wake, dead}, {27'h0, m_st[15:11]});
    for (int i = 0; i < 3; i++) begin
      logic c;
      c = (i == 0) ? int_cond : (i == 1) ? br_cond : wait_cond;
      chk("R6 selector condition", {31'h0, c}, {31'h0, ((m_st[7:0] & m_sm[i]) == m_sv[i])});
    end
    chk("R7 pointer ports", cmd_ptr, m_cp);
    chk("R7 high word port", cmd_ptr_hi, m_cph);
    chk(rd_tag(int'(rd_addr)), rd_data, exp_rd(int'(rd_addr)));
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_st = '0; m_cp = '0; m_cph = '0;
      for (int i = 0; i < 3; i++) begin m_sm[i] = '0; m_sv[i] = '0; end
      return;
    end
    if (hw_stb)
      for (int b = 0; b < 8; b++) if (hw_mask[b]) m_st[b] = hw_val[b];
    if (wr_en) begin
      int a = int'(wr_addr);
      if (a == 0) begin
        for (int b = 0; b < 16; b++)
          if (wr_data[16 + b] && (b >= 11 || b <= 7)) m_st[b] = wr_data[b];
      end else if (a == 8) m_cph = wr_data;
      else if (a == 12) m_cp = wr_data & 32'hFFFF_FFF0;
      else if (a >= 16 && a <= 24 && a % 4 == 0) begin
        m_sm[(a - 16) / 4] = wr_data[23:16];
        m_sv[(a - 16) / 4] = wr_data[7:0];
      end
    end
  endtask

  task automatic cyc(logic we, int wa, logic [31:0] wd, logic hs, logic [7:0] hm,
                     logic [7:0] hv, logic act, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    hw_stb = hs; hw_mask = hm; hw_val = hv; eng_active = act; rd_addr = AW'(ra);
    #1 compare_all();
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic wr(int a, logic [31:0] d, int ra);
    cyc(1, a, d, 0, 0, 0, eng_active, ra);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_st = '0; m_cp = '0; m_cph = '0;
    for (int i = 0; i < 3; i++) begin m_sm[i] = 'x; m_sv[i] = 'x; end
    rst_n = 0;
    @(posedge clk); #1 model_step();
    // R1: reset state, including writes attempted under reset
    cyc(1, 8, 32'hFFFF_FFFF, 1, 8'hFF, 8'hFF, 0, 8);
    cyc(0, 0, 0, 0, 0, 0, 0, 4);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0, 0, 0, 12);
    // R2/R9: start (mask run,pause,wake,dead; value run), wake, stop
    wr(0, 32'hD800_8000, 4);
    wr(0, 32'hD800_9000, 4);
    wr(0, 32'h2000_2000, 4);
    wr(0, 32'h8000_0000, 4);
    cyc(0, 0, 0, 0, 0, 0, 1, 4);
    // R3: active and reserved bits cannot be written
    cyc(1, 0, 32'h0700_0700, 0, 0, 0, 1, 4);
    cyc(0, 0, 0, 0, 0, 0, 0, 4);
    // R2: device bits by masked write; unmasked bits keep values
    wr(0, 32'h00FF_00A5, 4);
    wr(0, 32'h0003_0000, 4);
    // R4: hardware strobe and collision, software wins on bits 3:0
    cyc(0, 0, 0, 1, 8'hF0, 8'h30, 0, 4);
    cyc(1, 0, 32'h000F_0005, 1, 8'hFF, 8'hFF, 0, 4);
    cyc(0, 0, 0, 0, 0, 0, 0, 4);
    // R5/R6: selectors
    wr(16, 32'hFFF0_FFF5, 16);
    wr(20, 32'h0001_0001, 20);
    wr(24, 32'h0080_0000, 24);
    cyc(1, 0, 32'h0080_0000, 0, 0, 0, 0, 16);
    cyc(0, 0, 0, 0, 0, 0, 0, 24);
    // R7: pointer alignment; slot 5 at base 0x1000 is 0x1050
    wr(12, 32'h0000_1050, 12);
    wr(12, 32'h1234_567F, 12);
    wr(8, 32'hCAFE_0001, 8);
    // R8/R10: status write ignored, unmapped ignored
    wr(4, 32'hFFFF_FFFF, 4);
    wr(60, 32'hFFFF_FFFF, 60);
    wr(28, 32'hFFFF_FFFF, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 28);
    for (int k = 0; k < 4000; k++) begin
      int a, r;
      logic [31:0] d;
      a = ($urandom % 2) ? 0 : 4 * ($urandom % 16);
      r = 4 * ($urandom % 16) + (($urandom % 8 == 0) ? 1 : 0);
      d = $urandom;
      cyc($urandom % 2, a, d, $urandom % 2, 8'($urandom), 8'($urandom), $urandom % 2, r);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule